// File: doc/BRIEF.md
# Oscillator-Count Thermal Sensor Channel Controller

This block runs one temperature sensor channel. The sensor oscillator runs faster as the die gets hotter. A front end reports, in each reference clock cycle, how many oscillator edges it saw. The controller adds these edges over a fixed measurement window. It starts a new window at a fixed period, and both the window and the period are measured in reference clock cycles. Each finished count is compared against three programmable thresholds to find a thermal state.

The thermal state drives three action outputs: a frequency/voltage scaling request, a divide-by-two clock throttle and an emergency reset. Each action has its own enable bit. An interrupt becomes pending when a completed measurement has an enabled cause. Software acknowledges the interrupt by writing back the status word it has read.

Software reaches the block through a word-addressed register bus. Register writes take effect on the clock edge. Reads are combinational from the current register state.

Top module: `thsen_ctrl`

## Requirements
- R1: After reset the register words read as follows: word 0 (setup) is 0, word 2 is 0xFFFFFFFF, word 3 is 0x0000FFFF, words 6 and 7 are 0, and any unmapped word reads 0. While the period field (setup bits 23:8) or the window field (setup bits 31:24) is zero, no measurement ever completes and the valid flag (word 6 bit 9) stays 0.
- R2: A write to word 0 restarts measurement and clears the valid flag. With window field N, the count is the sum of the edge input over N*16 consecutive cycles. It is reported in word 7 bits 31:16. The valid flag is still 0 at N*16 cycles after the write edge and is 1 one cycle later.
- R3: When the sum exceeds 0xFFFF, the count saturates at 0xFFFF and the state field (word 6 bits 2:0) reads 5. A sum of exactly 0xFFFF or less is reported unchanged.
- R4: The state is set on each completed measurement. It is 3 if the count is strictly above threshold C (word 3 bits 15:0). Otherwise it is 2 if the count is above threshold B (word 2 bits 31:16). Otherwise it is 1 if the count is above threshold A (word 2 bits 15:0). Otherwise it is 0. A count equal to a threshold does not pass it. Threshold C is tested first, then B, then A.
- R5: The scaling request is high while the state is 1 or higher and setup bit 3 is set. The throttle is high while the state is 2 or higher and setup bit 1 is set. The emergency reset is high while the state is 3 or 5 and setup bit 2 is set.
- R6: The pending flag (word 6 bit 8) is set at a completion in any of these cases: an overflow with setup bit 4 set, a state of 2 or higher with setup bit 5 set, or a state of 3 or 5 with setup bit 6 set. The irq output equals the pending flag.
- R7: Writing word 6 with bit 8 set clears the pending flag. Writing it with bit 8 clear leaves the flag set. The other bits of a word 6 write are ignored. Writing back the value just read acknowledges the interrupt.
- R8: Setup bit 0 (stop) aborts any measurement in progress, clears the valid flag, forces state 0 and keeps the action outputs low. No measurement completes while it is set. Clearing it starts measurement again.
- R9: Measurements repeat on their own. With period field M, the next window starts M cycles after the previous one, so the next result appears M cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| osc_edges | input | EDGE_W (8) | Oscillator edges seen in this reference cycle |
| irq | output | 1 | Interrupt, high while the pending flag is set |
| dvfs_req | output | 1 | Frequency/voltage scaling request |
| div_req | output | 1 | Divide-by-two clock throttle request |
| trip_rst | output | 1 | Emergency thermal reset request |

## Verification
The bench samples the valid flag one cycle before and at the cycle of the expected completion. An off-by-one window would count one sample too many or too few, or would flag the result early.

It places counts exactly on a threshold and just above it. It also gives the thresholds in reverse order. A design that compares with greater-or-equal, or that tests the lower threshold first, would report the wrong state.

Two cases bound the overflow. A sum of 65280 must be kept as it is, while a sum of 69360 must saturate. A design that wraps around instead of saturating would report a small count and a low state.

Stop is applied while a result is held. The bench then waits long enough for several periods. A design that keeps measuring would set valid again or raise the emergency reset.

// File: rtl/thsen_pkg.sv
package thsen_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CNT_W    = 16;
    localparam int unsigned PER_W    = 16;
    localparam int unsigned WIN_N_W  = 8;

    localparam logic [2:0] A_SETUP  = 3'd0;
    localparam logic [2:0] A_THR_AB = 3'd2;
    localparam logic [2:0] A_THR_C  = 3'd3;
    localparam logic [2:0] A_STAT   = 3'd6;
    localparam logic [2:0] A_COUNT  = 3'd7;

    localparam int unsigned B_STOP   = 0;
    localparam int unsigned B_DIV_EN = 1;
    localparam int unsigned B_RST_EN = 2;
    localparam int unsigned B_DVF_EN = 3;
    localparam int unsigned B_OVF_IE = 4;
    localparam int unsigned B_DIV_IE = 5;
    localparam int unsigned B_RST_IE = 6;
    localparam int unsigned B_PEND   = 8;
    localparam int unsigned B_VALID  = 9;

    typedef enum logic [2:0] {
        TS_COLD = 3'd0,
        TS_WARM = 3'd1,
        TS_HOT  = 3'd2,
        TS_CRIT = 3'd3,
        TS_OVF  = 3'd5
    } tstate_e;
endpackage

// File: rtl/thsen_meas.sv
module thsen_meas #(
    parameter int unsigned M_W       = 16,
    parameter int unsigned N_W       = 8,
    parameter int unsigned EDGE_W    = 8,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned WIN_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              run,
    input  logic [M_W-1:0]    m_val,
    input  logic [N_W-1:0]    n_val,
    input  logic [EDGE_W-1:0] edges,
    output logic              done,
    output logic [CNT_W-1:0]  result,
    output logic              res_ovf
);
    localparam int unsigned WIN_W = N_W + WIN_SHIFT;

    typedef struct packed {
        logic             busy;
        logic [M_W-1:0]   per;
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] acc;
        logic             ovf;
    } meas_t;

    meas_t            q, d;
    logic [WIN_W-1:0] win_end;
    logic [CNT_W:0]   sum;

    always_comb begin
        win_end = {n_val, {WIN_SHIFT{1'b0}}} - WIN_W'(1);
        sum     = {1'b0, q.acc} + (CNT_W+1)'(edges);
        d       = q;
        done    = 1'b0;
        if (abort || !run) begin
            d = '0;
        end else begin
            d.per = (q.per >= m_val - M_W'(1)) ? '0 : q.per + M_W'(1);
            if (q.busy) begin
                if (q.ovf || sum[CNT_W]) begin
                    d.ovf = 1'b1;
                    d.acc = '1;
                end else begin
                    d.acc = sum[CNT_W-1:0];
                end
                d.win = q.win + WIN_W'(1);
                if (q.win == win_end) begin
                    done   = 1'b1;
                    d.busy = 1'b0;
                end
            end else if (q.per == '0) begin
                d.busy = 1'b1;
                d.win  = '0;
                d.acc  = '0;
                d.ovf  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign result  = d.acc;
    assign res_ovf = d.ovf;
endmodule

// File: rtl/thsen_classify.sv
module thsen_classify
    import thsen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic             ovf,
    input  logic [CNT_W-1:0] th_a,
    input  logic [CNT_W-1:0] th_b,
    input  logic [CNT_W-1:0] th_c,
    output tstate_e          state
);
    always_comb begin
        if (ovf)               state = TS_OVF;
        else if (count > th_c) state = TS_CRIT;
        else if (count > th_b) state = TS_HOT;
        else if (count > th_a) state = TS_WARM;
        else                   state = TS_COLD;
    end
endmodule

// File: rtl/thsen_ctrl.sv
module thsen_ctrl
    import thsen_pkg::*;
#(
    parameter int unsigned EDGE_W    = 8,
    parameter int unsigned WIN_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [EDGE_W-1:0] osc_edges,
    output logic              irq,
    output logic              dvfs_req,
    output logic              div_req,
    output logic              trip_rst
);
    typedef struct packed {
        logic [WORD_W-1:0] setup;
        logic [CNT_W-1:0]  th_a;
        logic [CNT_W-1:0]  th_b;
        logic [CNT_W-1:0]  th_c;
        tstate_e           state;
        logic [CNT_W-1:0]  count;
        logic              valid;
        logic              pend;
    } regs_t;

    regs_t            q, d;
    logic             wr_setup, meas_abort, meas_run;
    logic             meas_done, meas_ovf;
    logic [CNT_W-1:0] meas_cnt;
    tstate_e          cls_state;
    logic             cause;
    logic [PER_W-1:0] per_val;
    logic [WIN_N_W-1:0] win_val;
    logic             stop_q, ack_wr;
    logic             lvl_crit, lvl_hot;

    assign per_val    = q.setup[23:8];
    assign win_val    = q.setup[31:24];
    assign stop_q     = q.setup[B_STOP];
    assign wr_setup   = bus_wr && (bus_addr == A_SETUP);
    assign ack_wr     = bus_wr && (bus_addr == A_STAT) && bus_wdata[B_PEND];
    assign meas_abort = wr_setup || stop_q;
    assign meas_run   = !stop_q && (per_val != '0) && (win_val != '0);

    thsen_meas #(
        .M_W      (PER_W),
        .N_W      (WIN_N_W),
        .EDGE_W   (EDGE_W),
        .CNT_W    (CNT_W),
        .WIN_SHIFT(WIN_SHIFT)
    ) u_meas (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort  (meas_abort),
        .run    (meas_run),
        .m_val  (per_val),
        .n_val  (win_val),
        .edges  (osc_edges),
        .done   (meas_done),
        .result (meas_cnt),
        .res_ovf(meas_ovf)
    );

    thsen_classify #(.CNT_W(CNT_W)) u_cls (
        .count(meas_cnt),
        .ovf  (meas_ovf),
        .th_a (q.th_a),
        .th_b (q.th_b),
        .th_c (q.th_c),
        .state(cls_state)
    );

    always_comb begin
        cause = (meas_ovf && q.setup[B_OVF_IE])
             || ((cls_state != TS_COLD) && (cls_state != TS_WARM) && q.setup[B_DIV_IE])
             || ((cls_state == TS_CRIT || cls_state == TS_OVF) && q.setup[B_RST_IE]);

        d = q;
        if (bus_wr) begin
            case (bus_addr)
                A_SETUP:  d.setup = bus_wdata;
                A_THR_AB: begin
                    d.th_a = bus_wdata[15:0];
                    d.th_b = bus_wdata[31:16];
                end
                A_THR_C:  d.th_c = bus_wdata[15:0];
                A_STAT:   if (bus_wdata[B_PEND]) d.pend = 1'b0;
                default:  ;
            endcase
        end
        if (wr_setup) d.valid = 1'b0;
        if (meas_done) begin
            d.count = meas_cnt;
            d.valid = 1'b1;
            d.state = cls_state;
            if (cause) d.pend = 1'b1;
        end
        if (d.setup[B_STOP]) begin
            d.valid = 1'b0;
            d.state = TS_COLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.th_a  <= '1;
            q.th_b  <= '1;
            q.th_c  <= '1;
            q.state <= TS_COLD;
        end else begin
            q <= d;
        end
    end

    assign lvl_crit = (q.state == TS_CRIT) || (q.state == TS_OVF);
    assign lvl_hot  = lvl_crit || (q.state == TS_HOT);
    assign dvfs_req = q.setup[B_DVF_EN] && (q.state != TS_COLD);
    assign div_req  = q.setup[B_DIV_EN] && lvl_hot;
    assign trip_rst = q.setup[B_RST_EN] && lvl_crit;
    assign irq      = q.pend;

    always_comb begin
        case (bus_addr)
            A_SETUP:  bus_rdata = q.setup;
            A_THR_AB: bus_rdata = {q.th_b, q.th_a};
            A_THR_C:  bus_rdata = {16'h0000, q.th_c};
            A_STAT:   bus_rdata = {22'd0, q.valid, q.pend, 5'd0, q.state};
            A_COUNT:  bus_rdata = {q.count, 16'h0000};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/thsen_ctrl_chk.sv
module thsen_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop,
    input logic       per_zero,
    input logic [2:0] state,
    input logic       valid,
    input logic       done,
    input logic       res_ovf,
    input logic       ovf_ie,
    input logic       ack_wr,
    input logic       irq,
    input logic       dvfs_req,
    input logic       div_req,
    input logic       trip_rst
);
    // R1
    a_r1_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        per_zero |-> !done);
    // R3
    a_r3_ovf_state: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_ovf |=> state == 3'd5);
    // R5
    a_r5_trip_level: assert property (@(posedge clk) disable iff (!rst_n)
        trip_rst |-> (state == 3'd3 || state == 3'd5));
    // R6
    a_r6_ovf_irq: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_ovf && ovf_ie |=> irq);
    // R7
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr && !done |=> !irq);
    // R8
    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> !dvfs_req && !div_req && !trip_rst && !valid);
endmodule

bind thsen_ctrl thsen_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop    (stop_q),
    .per_zero(per_val == '0),
    .state   (q.state),
    .valid   (q.valid),
    .done    (meas_done),
    .res_ovf (meas_ovf),
    .ovf_ie  (q.setup[4]),
    .ack_wr  (ack_wr),
    .irq     (irq),
    .dvfs_req(dvfs_req),
    .div_req (div_req),
    .trip_rst(trip_rst)
);

// File: tb/test_thsen_ctrl.sv
module test_thsen_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [7:0]  osc_edges = 8'd0;
    logic        irq, dvfs_req, div_req, trip_rst;

    int n_chk = 0;
    int n_bad = 0;
    int th_a = 16'hFFFF, th_b = 16'hFFFF, th_c = 16'hFFFF;

    typedef struct packed {
        logic [15:0] cnt;
        logic [2:0]  st;
        logic        irq, dv, dd, tr;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    thsen_ctrl i_thsen_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_edges(osc_edges),
        .irq(irq), .dvfs_req(dvfs_req), .div_req(div_req), .trip_rst(trip_rst)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [31:0] mk_setup(input logic stop, input logic [5:0] en, input int m, input int n);
        return {n[7:0], m[15:0], 1'b0, en, stop};
    endfunction

    task automatic set_th(input int a, input int b, input int c);
        th_a = a; th_b = b; th_c = c;
        wr(3'd2, {b[15:0], a[15:0]});
        wr(3'd3, {16'd0, c[15:0]});
    endtask

    function automatic exp_t predict(input logic [5:0] en, input int e, input int n);
        exp_t x;
        int raw;
        int lvl;
        logic ovf;
        raw = e * n * 16;
        ovf = raw > 65535;
        x.cnt = ovf ? 16'hFFFF : raw[15:0];
        if (ovf)              x.st = 3'd5;
        else if (raw > th_c)  x.st = 3'd3;
        else if (raw > th_b)  x.st = 3'd2;
        else if (raw > th_a)  x.st = 3'd1;
        else                  x.st = 3'd0;
        lvl = ovf ? 3 : int'(x.st);
        x.irq = (ovf && en[3]) || (lvl >= 2 && en[4]) || (lvl == 3 && en[5]);
        x.dv  = en[2] && lvl >= 1;
        x.dd  = en[0] && lvl >= 2;
        x.tr  = en[1] && lvl >= 3;
        return x;
    endfunction

    task automatic check_result(input string req);
        exp_t x;
        logic [31:0] v;
        x = sb_q.pop_front();
        rd(3'd7, v);
        chk(req, "count", {16'd0, v[31:16]}, {16'd0, x.cnt});
        rd(3'd6, v);
        chk(req, "state", {29'd0, v[2:0]}, {29'd0, x.st});
        chk("R2", "valid", {31'd0, v[9]}, 32'd1);
        chk("R6", "irq", {31'd0, irq}, {31'd0, x.irq});
        chk("R5", "actions", {29'd0, dvfs_req, div_req, trip_rst}, {29'd0, x.dv, x.dd, x.tr});
    endtask

    task automatic measure(input string req, input logic [5:0] en, input int m, input int n, input int e);
        logic [31:0] v;
        wr(3'd6, 32'h100);
        osc_edges = e[7:0];
        sb_q.push_back(predict(en, e, n));
        wr(3'd0, mk_setup(1'b0, en, m, n));
        repeat (n * 16) @(negedge clk);
        rd(3'd6, v);
        chk("R2", "valid before window end", {31'd0, v[9]}, 32'd0);
        @(negedge clk);
        check_result(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        exp_t x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, v); chk("R1", "setup reset", v, 32'h0);
        rd(3'd2, v); chk("R1", "thr ab reset", v, 32'hFFFFFFFF);
        rd(3'd3, v); chk("R1", "thr c reset", v, 32'h0000FFFF);
        rd(3'd6, v); chk("R1", "status reset", v, 32'h0);
        rd(3'd7, v); chk("R1", "count reset", v, 32'h0);
        rd(3'd1, v); chk("R1", "unmapped", v, 32'h0);
        chk("R1", "outputs reset", {28'd0, irq, dvfs_req, div_req, trip_rst}, 32'h0);
        // R1 zero window field: no measurement
        osc_edges = 8'd3;
        wr(3'd0, mk_setup(1'b0, 6'h3F, 100, 0));
        repeat (300) @(negedge clk);
        rd(3'd6, v); chk("R1", "no result with zero window", {31'd0, v[9]}, 32'd0);

        set_th(50, 100, 200);
        measure("R4", 6'h3F, 100, 2, 3);           // 96 -> state 1

        // R9 periodic repeat: next result M cycles later
        osc_edges = 8'd4;
        x = predict(6'h3F, 4, 2);                  // 128 -> state 2
        sb_q.push_back(x);
        repeat (99) @(negedge clk);
        rd(3'd7, v); chk("R9", "count held before next period", {16'd0, v[31:16]}, 32'd96);
        @(negedge clk);
        check_result("R9");

        // R7 ignored bits and write-back acknowledge
        wr(3'd6, 32'hFFFFFEFF);
        rd(3'd6, v);
        chk("R7", "pend kept when bit clear", {31'd0, v[8]}, 32'd1);
        chk("R7", "state unchanged by write", {29'd0, v[2:0]}, 32'd2);
        wr(3'd6, v);
        chk("R7", "irq after write-back", {31'd0, irq}, 32'd0);
        rd(3'd6, v); chk("R7", "state after ack", {29'd0, v[2:0]}, 32'd2);

        measure("R4", 6'h3F, 1000, 2, 7);          // 224 -> state 3
        set_th(96, 100, 200);
        measure("R4", 6'h3F, 1000, 2, 3);          // equal to A -> state 0
        set_th(95, 100, 200);
        measure("R4", 6'h3F, 1000, 2, 3);          // just above A -> state 1
        set_th(250, 250, 50);
        measure("R4", 6'h3F, 1000, 2, 3);          // C tested first -> state 3
        set_th(50, 100, 200);
        measure("R3", 6'h3F, 1000, 17, 240);       // 65280, no overflow
        measure("R3", 6'h3F, 1000, 17, 255);       // 69360 saturates
        measure("R5", 6'h00, 1000, 2, 7);          // enables off
        measure("R6", 6'h30, 1000, 2, 5);          // divider irq only, state 2

        // R8 stop
        measure("R8", 6'h3F, 1000, 2, 7);
        wr(3'd0, mk_setup(1'b1, 6'h3F, 100, 2));
        rd(3'd6, v);
        chk("R8", "valid/state on stop", {22'd0, v[9], 6'd0, v[2:0]}, 32'd0);
        chk("R8", "actions on stop", {29'd0, dvfs_req, div_req, trip_rst}, 32'd0);
        repeat (1000) @(negedge clk);
        rd(3'd6, v); chk("R8", "no result while stopped", {31'd0, v[9]}, 32'd0);
        measure("R8", 6'h3F, 1000, 2, 7);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule